// File: doc/BRIEF.md
# Disk Status-Read Wait-State Generator

This block holds the CPU in wait states while a disk transfer is under way, so that a slow processor can keep pace with a fast drive. Software arms or disarms the mechanism by writing a control byte. While the block is armed, every read of the disk controller's status register raises a wait request to the CPU. That request stays up until the controller shows progress: the status busy bit drops, the data-request line rises, or the interrupt line rises.

Two of the three release causes leave the block armed, so the next status read stalls the CPU again. The interrupt cause is different: it removes the wait and also disarms the block, which ends the polling loop. The data-request and interrupt lines come from another clock domain. Each passes through a two-flop synchronizer before the block uses it. The busy bit arrives on the same clock as the block and is used directly. Address decoding sits outside the block, which sees only the write and read strobes.

Top module: `disk_wait_gen`

## Requirements
- R1: After reset, `armedOut` and `waitOut` are both 0. Asserting `rstN` low clears both at once, even while a wait is in progress.
- R2: A control write (`ctlWrEn`=1) with bit 7=1 and bit 5=1 sets `armedOut` to 1 from the next cycle.
- R3: A control write with bit 7=1 and bit 5=0 clears `armedOut` from the next cycle. If a wait is in progress, it also clears `waitOut` in that same next cycle.
- R4: A control write with bit 7=0 changes neither `armedOut` nor `waitOut`, whatever the other bits hold.
- R5: When the block is armed and no release cause is active, a status read (`statusRdEn`=1) drives `waitOut` to 1 from the next cycle. `waitOut` stays at 1 until a release cause occurs.
- R6: A status read while `armedOut`=0 never drives `waitOut` to 1.
- R7: While waiting, `busyIn`=0 clears `waitOut` in the next cycle and leaves `armedOut` at 1. A later status read with `busyIn`=1 waits again.
- R8: `drqAsync` passes through a two-flop synchronizer, so a change is seen by the logic after two clock edges. While waiting, a synchronized 1 on this line clears `waitOut` in the next cycle and leaves `armedOut` at 1. Seen from the port, `waitOut` falls three edges after `drqAsync` rises.
- R9: `irqAsync` passes through the same kind of synchronizer. While waiting, a synchronized 1 on this line clears both `waitOut` and `armedOut` in the next cycle.
- R10: If a release cause is already active when a status read arrives, `waitOut` stays 0 and `armedOut` is unchanged. This holds even when the cause is the synchronized interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlWrEn | input | 1 | Control-byte write strobe |
| ctlWrData | input | 8 | Control byte: bit 7 enables the update, bit 5 gives the new armed value |
| statusRdEn | input | 1 | Strobe for a CPU read of the disk status register |
| busyIn | input | 1 | Busy bit from disk status |
| drqAsync | input | 1 | Data request from the disk controller, asynchronous |
| irqAsync | input | 1 | Interrupt request from the disk controller, asynchronous |
| waitOut | output | 1 | Wait request to the CPU |
| armedOut | output | 1 | Block is armed |

## Verification
The block holds only two state bits, the armed flag and the wait flag, and both are ports, so a wrong internal state shows at the ports one cycle after the event that caused it. The exception is a fault in the synchronizers. A missing or extra stage moves the release of the wait one cycle early or late, so the bench samples each release exactly on the third edge after the asynchronous input changes. An interrupt release that fails to disarm appears as a wait on the next status read. A spurious disarm appears as a missing wait.

// File: rtl/disk_wait_pkg.sv
package disk_wait_pkg;
  // Strobes from control to datapath; in each pair the clear wins.
  typedef struct packed {
    logic setWait;
    logic clrWait;
    logic setArm;
    logic clrArm;
  } waitStrobes_t;
endpackage

// File: rtl/disk_wait_sync.sv
module disk_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[LAST];
endmodule

// File: rtl/disk_wait_dp.sv
module disk_wait_dp
  import disk_wait_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         drqAsync,
  input  logic         irqAsync,
  input  waitStrobes_t strobes,
  output logic         drqSync,
  output logic         irqSync,
  output logic         armedQ,
  output logic         waitQ
);
  disk_wait_sync #(.STAGES(SYNC_STAGES)) u_drqSync (
    .clk(clk), .rstN(rstN), .asyncIn(drqAsync), .syncOut(drqSync)
  );
  disk_wait_sync #(.STAGES(SYNC_STAGES)) u_irqSync (
    .clk(clk), .rstN(rstN), .asyncIn(irqAsync), .syncOut(irqSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      waitQ  <= 1'b0;
    end else begin
      armedQ <= (armedQ | strobes.setArm)  & ~strobes.clrArm;
      waitQ  <= (waitQ  | strobes.setWait) & ~strobes.clrWait;
    end
  end
endmodule

// File: rtl/disk_wait_ctl.sv
module disk_wait_ctl
  import disk_wait_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int UPD_BIT = 7,
  parameter int ARM_BIT = 5
) (
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             statusRdEn,
  input  logic             busyIn,
  input  logic             drqSync,
  input  logic             irqSync,
  input  logic             armedQ,
  input  logic             waitQ,
  output waitStrobes_t     strobes
);
  logic updWr, armReq, disarmReq, releaseNow;

  always_comb begin
    updWr      = ctlWrEn & ctlWrData[UPD_BIT];
    armReq     = updWr & ctlWrData[ARM_BIT];
    disarmReq  = updWr & ~ctlWrData[ARM_BIT];
    releaseNow = ~busyIn | drqSync | irqSync;

    strobes.setArm  = armReq;
    strobes.clrArm  = disarmReq | (waitQ & irqSync);
    strobes.setWait = statusRdEn & armedQ & ~releaseNow & ~disarmReq;
    strobes.clrWait = disarmReq | (waitQ & releaseNow);
  end
endmodule

// File: rtl/disk_wait_gen.sv
module disk_wait_gen
  import disk_wait_pkg::*;
#(
  parameter int CTL_W       = 8,
  parameter int UPD_BIT     = 7,
  parameter int ARM_BIT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             statusRdEn,
  input  logic             busyIn,
  input  logic             drqAsync,
  input  logic             irqAsync,
  output logic             waitOut,
  output logic             armedOut
);
  waitStrobes_t strobes;
  logic drqSync, irqSync, armedQ, waitQ;

  disk_wait_ctl #(.CTL_W(CTL_W), .UPD_BIT(UPD_BIT), .ARM_BIT(ARM_BIT)) u_ctl (
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statusRdEn(statusRdEn),
    .busyIn(busyIn), .drqSync(drqSync), .irqSync(irqSync),
    .armedQ(armedQ), .waitQ(waitQ), .strobes(strobes)
  );

  disk_wait_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .drqAsync(drqAsync), .irqAsync(irqAsync),
    .strobes(strobes), .drqSync(drqSync), .irqSync(irqSync),
    .armedQ(armedQ), .waitQ(waitQ)
  );

  assign waitOut  = waitQ;
  assign armedOut = armedQ;
endmodule

// File: rtl/disk_wait_chk.sv
module disk_wait_chk #(
  parameter int CTL_W   = 8,
  parameter int UPD_BIT = 7,
  parameter int ARM_BIT = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic [CTL_W-1:0] ctlWrData,
  input logic             statusRdEn,
  input logic             busyIn,
  input logic             drqSync,
  input logic             irqSync,
  input logic             waitOut,
  input logic             armedOut
);
  assert_arm_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && ctlWrData[UPD_BIT] && ctlWrData[ARM_BIT] |=> armedOut);

  assert_disarm_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && ctlWrData[UPD_BIT] && !ctlWrData[ARM_BIT] |=> !armedOut && !waitOut);

  assert_wait_from_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitOut) |-> $past(statusRdEn));

  assert_disarmed_no_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    !armedOut |=> !waitOut);

  assert_wait_needs_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |-> armedOut);

  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    waitOut && !busyIn |=> !waitOut);

  assert_drq_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitOut && drqSync |=> !waitOut);

  assert_irq_disarm_R9: assert property (@(posedge clk) disable iff (!rstN)
    waitOut && irqSync |=> !waitOut && !armedOut);
endmodule

bind disk_wait_gen disk_wait_chk #(.CTL_W(CTL_W), .UPD_BIT(UPD_BIT), .ARM_BIT(ARM_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .statusRdEn(statusRdEn), .busyIn(busyIn), .drqSync(drqSync),
  .irqSync(irqSync), .waitOut(waitOut), .armedOut(armedOut)
);

// File: tb/disk_wait_gen_tb.sv
module disk_wait_gen_tb;
  // Vector layout: [18:15] requirement, [14] write, [13:6] data, [5] read,
  // [4] busy, [3] drq, [2] irq, [1] expected wait, [0] expected armed
  function automatic logic [18:0] v(int r, bit wr, logic [7:0] d, bit rd,
                                    bit bsy, bit dq, bit iq, bit ew, bit ea);
    return {4'(r), wr, d, rd, bsy, dq, iq, ew, ea};
  endfunction

  localparam int NV = 38;
  localparam logic [18:0] VEC [NV] = '{
    v(1, 0,8'h00,0, 1,0,0, 0,0),  // 0  R1 idle
    v(6, 0,8'h00,1, 1,0,0, 0,0),  // 1  R6 read while disarmed
    v(2, 1,8'hA0,0, 1,0,0, 0,1),  // 2  R2 arm
    v(5, 0,8'h00,1, 1,0,0, 1,1),  // 3  R5 read -> wait
    v(5, 0,8'h00,0, 1,0,0, 1,1),  // 4  R5 held
    v(7, 0,8'h00,0, 0,0,0, 0,1),  // 5  R7 busy low release
    v(7, 0,8'h00,0, 1,0,0, 0,1),  // 6
    v(7, 0,8'h00,1, 1,0,0, 1,1),  // 7  R7 waits again
    v(8, 0,8'h00,0, 1,1,0, 1,1),  // 8  R8 drq in sync
    v(8, 0,8'h00,0, 1,1,0, 1,1),  // 9
    v(8, 0,8'h00,0, 1,1,0, 0,1),  // 10 R8 release, still armed
    v(8, 0,8'h00,0, 1,0,0, 0,1),  // 11
    v(8, 0,8'h00,0, 1,0,0, 0,1),  // 12
    v(5, 0,8'h00,1, 1,0,0, 1,1),  // 13 R5
    v(9, 0,8'h00,0, 1,0,1, 1,1),  // 14 R9 irq in sync
    v(9, 0,8'h00,0, 1,0,1, 1,1),  // 15
    v(9, 0,8'h00,0, 1,0,1, 0,0),  // 16 R9 release and disarm
    v(9, 0,8'h00,0, 1,0,0, 0,0),  // 17
    v(9, 0,8'h00,0, 1,0,0, 0,0),  // 18
    v(3, 1,8'h80,0, 1,0,0, 0,0),  // 19 R3 disarm when disarmed
    v(4, 1,8'h20,0, 1,0,0, 0,0),  // 20 R4 bit7 clear ignored
    v(4, 0,8'h00,1, 1,0,0, 0,0),  // 21 R4 still disarmed
    v(2, 1,8'hE0,0, 1,0,0, 0,1),  // 22 R2
    v(5, 0,8'h00,1, 1,0,0, 1,1),  // 23 R5
    v(3, 1,8'h80,0, 1,0,0, 0,0),  // 24 R3 disarm kills wait
    v(2, 1,8'hA0,0, 1,0,0, 0,1),  // 25 R2
    v(10,0,8'h00,1, 0,0,0, 0,1),  // 26 R10 busy already low
    v(4, 1,8'h5F,0, 1,0,0, 0,1),  // 27 R4 ignored, stays armed
    v(5, 0,8'h00,1, 1,0,0, 1,1),  // 28 R5
    v(4, 1,8'h20,0, 1,0,0, 1,1),  // 29 R4 ignored while waiting
    v(2, 1,8'hA0,0, 1,0,0, 1,1),  // 30 R2 re-arm keeps wait
    v(7, 0,8'h00,0, 0,0,0, 0,1),  // 31 R7
    v(10,0,8'h00,0, 1,0,1, 0,1),  // 32 R10 irq in sync
    v(10,0,8'h00,0, 1,0,1, 0,1),  // 33
    v(10,0,8'h00,1, 1,0,1, 0,1),  // 34 R10 read with irq high
    v(10,0,8'h00,0, 1,0,0, 0,1),  // 35
    v(10,0,8'h00,0, 1,0,0, 0,1),  // 36
    v(5, 0,8'h00,1, 1,0,0, 1,1)   // 37 R5
  };

  logic clk = 0, rstN = 0;
  logic ctlWrEn = 0, statusRdEn = 0, busyIn = 1, drqAsync = 0, irqAsync = 0;
  logic [7:0] ctlWrData = '0;
  logic waitOut, armedOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disk_wait_gen u_dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .statusRdEn(statusRdEn), .busyIn(busyIn), .drqAsync(drqAsync),
    .irqAsync(irqAsync), .waitOut(waitOut), .armedOut(armedOut)
  );

  task automatic check(string req, logic ew, logic ea);
    nChecks++;
    if (waitOut !== ew || armedOut !== ea) begin
      nFails++;
      $display("FAIL %s: wait/armed actual %b/%b expected %b/%b",
               req, waitOut, armedOut, ew, ea);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rstN = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ctlWrEn, ctlWrData, statusRdEn, busyIn, drqAsync, irqAsync} = VEC[i][14:2];
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec %0d", VEC[i][18:15], i), VEC[i][1], VEC[i][0]);
    end
    // R1: asynchronous reset in the middle of a wait
    @(negedge clk);
    {ctlWrEn, statusRdEn} = 2'b00;
    rstN = 0;
    #1 check("R1 reset mid-wait", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1;
    statusRdEn = 1;
    @(posedge clk);
    #1 check("R1 R6 read after reset", 1'b0, 1'b0);
    @(negedge clk);
    statusRdEn = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule